// File: doc/BRIEF.md
# Aligned Dual-Ratio Clock Divider

This block derives two slower clocks from a single input clock. One output always runs at half the input rate. The other runs at a quarter or a sixth of the input rate, depending on a select input. Both outputs advance from the same internal advance condition, so every edge the two outputs have in common lands on the same rising input edge. A third output marks each rising edge that the two outputs share, which lets downstream logic find a common phase reference.

The enable input is active low. It is sampled on the falling input edge, so the dividers can start or stop only while the input clock is low, and no output pulse is ever cut short. While the dividers are held, both outputs keep their values. When the hold is released, counting resumes from the held position. An asynchronous master reset forces both outputs low and returns every counter to its start state. This is how several instances are brought into the same phase.

Top module: `clkdiv_top`

## Requirements
- R1: While enabled, `q_div2` inverts on every rising input edge, giving a period of 2 input cycles with one cycle high and one low.
- R2: With `div_sel` = 0, `q_div46` has a period of 4 enabled input cycles: 2 high, then 2 low.
- R3: With `div_sel` = 1, `q_div46` has a period of 6 enabled input cycles: 3 high, then 3 low.
- R4: Every rise of `q_div46` happens on the same input edge as a rise of `q_div2`. After reset, both outputs rise on the first enabled rising edge.
- R5: `en_n` is sampled on the falling input edge. A sampled 1 holds both outputs at their present values across the next rising edge. A sampled 0 lets them advance.
- R6: When the hold is released, the dividers continue from the held position rather than from the reset state.
- R7: While `mr` is 1, both outputs and `phase_out` are 0 at once, without waiting for a clock edge. After `mr` falls, the dividers start again from the beginning of a period, and the enable stays in the hold state until the next falling edge samples `en_n`.
- R8: `phase_out` is 1 for exactly one input period after each edge on which both outputs rise. It is 0 at all other times, including while the dividers are held.
- R9: `div_sel` is sampled only on the edge that starts a new `q_div46` period. A change made partway through a period takes effect at the next period start.
- R10: However `en_n` and `div_sel` are toggled, no level on `q_div2` or `q_div46` lasts less than one input period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock. The dividers use its rising edge; the enable is sampled on its falling edge. |
| mr | input | 1 | Asynchronous master reset, active high. |
| en_n | input | 1 | Active-low enable; 1 holds the dividers. |
| div_sel | input | 1 | Ratio select for `q_div46`: 0 selects divide-by-4, 1 selects divide-by-6. |
| q_div2 | output | 1 | Divide-by-2 output. |
| q_div46 | output | 1 | Divide-by-4 or divide-by-6 output. |
| phase_out | output | 1 | One-period pulse that follows each shared rising edge. |

## Verification
Two events can land on the same edge. The first is a `div_sel` change that arrives on the edge that closes a `q_div46` period. The second is a hold sampled just before a shared rising edge, which must suppress both the rise and the `phase_out` pulse. Both cases are driven deliberately, and a long stretch of pseudo-random enable and select patterns covers every alignment between them. Each result is compared against an arithmetic model in the bench. The model tracks the count of enabled edges, the position in the current period and the ratio latched at that period's start. Independent timestamp monitors measure how long each output level lasts.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // strobes from control to datapath, valid for the coming rising edge
  typedef struct packed {
    logic advance;  // dividers step on this edge
    logic set46;    // slow output starts its high half
    logic clr46;    // slow output starts its low half
  } divStrb_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input  logic     clk,
  input  logic     mr,
  input  logic     en_n,
  input  logic     div_sel,
  output divStrb_t strb
);
  localparam int CNT_W = $clog2(DIV_HI);
  localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(DIV_LO / 2);
  localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(DIV_HI / 2);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);

  logic             enHeld;
  logic             modeHi;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfPt;
  logic [CNT_W-1:0] lastPt;

  // enable captured while the clock is high-to-low, so a step is decided
  // half a period before the rising edge it affects
  always_ff @(negedge clk or posedge mr) begin
    if (mr) enHeld <= 1'b1;
    else    enHeld <= en_n;
  end

  always_comb begin
    halfPt       = modeHi ? HALF_HI : HALF_LO;
    lastPt       = modeHi ? LAST_HI : LAST_LO;
    strb.advance = !enHeld;
    strb.set46   = !enHeld && (cnt == '0);
    strb.clr46   = !enHeld && (cnt == halfPt);
  end

  // period position; ratio latched only when a new period begins
  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      cnt    <= '0;
      modeHi <= 1'b0;
    end else if (strb.advance) begin
      if (cnt == '0) modeHi <= div_sel;
      cnt <= (cnt == lastPt) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     mr,
  input  divStrb_t strb,
  output logic     q_div2,
  output logic     q_div46,
  output logic     phase_out
);
  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      q_div2    <= 1'b0;
      q_div46   <= 1'b0;
      phase_out <= 1'b0;
    end else begin
      if (strb.advance) q_div2 <= !q_div2;
      if (strb.set46)      q_div46 <= 1'b1;
      else if (strb.clr46) q_div46 <= 1'b0;
      // shared rise: slow output starting high while fast one is low
      phase_out <= strb.set46 && !q_div2;
    end
  end
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input  logic clk,
  input  logic mr,
  input  logic en_n,
  input  logic div_sel,
  output logic q_div2,
  output logic q_div46,
  output logic phase_out
);
  divStrb_t strb;

  clkdiv_ctrl #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_ctrl (
    .clk(clk), .mr(mr), .en_n(en_n), .div_sel(div_sel), .strb(strb)
  );

  clkdiv_dp u_dp (
    .clk(clk), .mr(mr), .strb(strb),
    .q_div2(q_div2), .q_div46(q_div46), .phase_out(phase_out)
  );
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker (
  input logic clk,
  input logic mr,
  input logic advance,
  input logic q_div2,
  input logic q_div46,
  input logic phase_out
);
  assert_div2_toggle_R1: assert property (@(posedge clk) disable iff (mr)
    advance |=> (q_div2 != $past(q_div2)));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (mr)
    !advance |=> ($stable(q_div2) && $stable(q_div46)));

  assert_rise_aligned_R4: assert property (@(posedge clk) disable iff (mr)
    $rose(q_div46) |-> $rose(q_div2));

  assert_phase_on_rise_R8: assert property (@(posedge clk) disable iff (mr)
    phase_out |-> (q_div2 && q_div46));

  assert_phase_single_R8: assert property (@(posedge clk) disable iff (mr)
    phase_out |=> !phase_out);

  assert_phase_held_low_R8: assert property (@(posedge clk) disable iff (mr)
    !advance |=> !phase_out);

  assert_reset_low_R7: assert property (@(negedge clk)
    mr |-> (!q_div2 && !q_div46 && !phase_out));
endmodule

bind clkdiv_top clkdiv_checker u_chk (
  .clk(clk), .mr(mr), .advance(strb.advance),
  .q_div2(q_div2), .q_div46(q_div46), .phase_out(phase_out)
);

// File: tb/tb_clkdiv_top.sv
module tb_clkdiv_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic mr, en_n, div_sel;
  logic q_div2, q_div46, phase_out;

  int checks = 0;
  int fails  = 0;

  // model state
  bit started;
  int pos, plen;
  bit q2e, q46e, phe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clkdiv_top dut (
    .clk(clk), .mr(mr), .en_n(en_n), .div_sel(div_sel),
    .q_div2(q_div2), .q_div46(q_div46), .phase_out(phase_out)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    started = 0; pos = 0; plen = 4; q2e = 0; q46e = 0; phe = 0;
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "q_div2", q_div2, q2e);
    chk(tag, "q_div46", q_div46, q46e);
    chk(tag, "phase_out", phase_out, phe);
  endtask

  // entered and left at rising edge + 3
  task automatic step(input logic e, input logic s, input string tag);
    bit capt;
    en_n = e; div_sel = s;
    @(negedge clk); capt = (e == 1'b0);
    @(posedge clk); #3;
    if (capt) begin
      q2e = !q2e;
      if (!started || pos == plen) begin
        plen = s ? 6 : 4; pos = 1; started = 1;
      end else pos++;
      q46e = (pos <= plen / 2);
      phe  = (pos == 1);
    end else phe = 0;
    checkAll(tag);
  endtask

  // R10: level duration monitors
  time t2 = 0, t46 = 0;
  bit arm2 = 0, arm46 = 0;
  always @(q_div2) begin
    if (!mr && arm2) begin
      checks++;
      if ($time - t2 < CLK_PERIOD) begin
        fails++;
        $display("FAIL R10 q_div2 level lasted %0t expected >= %0d", $time - t2, CLK_PERIOD);
      end
    end
    t2 = $time; arm2 = !mr;
  end
  always @(q_div46) begin
    if (!mr && arm46) begin
      checks++;
      if ($time - t46 < CLK_PERIOD) begin
        fails++;
        $display("FAIL R10 q_div46 level lasted %0t expected >= %0d", $time - t46, CLK_PERIOD);
      end
    end
    t46 = $time; arm46 = !mr;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired got hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    mr = 1'b1; en_n = 1'b1; div_sel = 1'b0;
    modelReset();
    @(posedge clk); #3;
    checkAll("R7");
    mr = 1'b0;
    // first enabled edge: both rise, phase pulses (R4)
    step(1'b0, 1'b0, "R4");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R2");
    // mid-period select change, applied at next period start (R9)
    step(1'b0, 1'b1, "R9");
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, "R3");
    // back to 4 on a period boundary
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, "R9");
    // hold: outputs frozen, phase low (R5)
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R5");
    // release: continue from held position (R6)
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R6");
    // hold landing in many period positions, with ratio 6
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i <= k; i++) step(1'b0, 1'b1, "R6");
      step(1'b1, 1'b1, "R5");
      step(1'b1, 1'b0, "R5");
    end
    // pseudo-random enable and select (R10 monitors run alongside)
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[3], lf[7], "R10");
    end
    // asynchronous reset mid-run (R7)
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R3");
    mr = 1'b1;
    #1;
    modelReset();
    chk("R7", "q_div2 async", q_div2, 1'b0);
    chk("R7", "q_div46 async", q_div46, 1'b0);
    chk("R7", "phase_out async", phase_out, 1'b0);
    @(posedge clk); #3;
    checkAll("R7");
    mr = 1'b0;
    // restart in ratio 6 after reset
    step(1'b0, 1'b1, "R4");
    for (int i = 0; i < 18; i++) step(1'b0, 1'b1, "R3");
    // R1 explicit toggle sweep
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R1");
    // phase spacing sweep in ratio 4 (R8)
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, "R8");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule